// File: doc/BRIEF.md
# Quasi-Bidirectional Port with Shared Pin Functions

This block is a seven-pin general-purpose port for a small 8-bit controller. There is no direction register. A pin whose latch bit holds 1 is released to a weak pull-up, and software can then read it as an input. A pin whose latch bit holds 0 is pulled low by the output driver. Software writes the latch through a simple register bus. A read of the same address returns the live pin levels, not the latch.

Separate control registers hand individual pins to on-chip peripherals:

- Two pins go to the analog-converter inputs.
- Two pins form a half-frequency sync input/output pair.
- One pin carries a push-pull self-test pattern, but only while the sync logic runs free.
- Two pins become external interrupt inputs. Each of these passes through a filtered, hysteretic synchronizer before it reaches the interrupt logic.

The peripherals themselves sit outside this block. It only routes drive, enable, pull-up and level signals to and from them.

Top module: `qbio_port`

## Requirements
- R1: After a synchronous active-low reset, the latch holds 0x7F, both control registers read as all ones internally, and both interrupt enables are 0. As a result every pin has pin_oe=0 and pin_pu=1, adc_sel=00, half_in=0 and int_lvl=11.
- R2: A write to address 0x01 loads bus_wdata[6:0] into the latch on the next clock edge.
  - On an ordinary pin, latch bit 0 gives pin_oe=1, pin_out=0 and pin_pu=0.
  - On an ordinary pin, latch bit 1 gives pin_oe=0, pin_out=0 and pin_pu=1.
- R3: With bus_addr=0x01, bus_rdata is {1'b0, pin_in[6:0]}. It shows the pin levels, not the latch contents.
- R4: Write-only register 0x10 holds two active-low analog enables, bit 0 for pin 0 and bit 1 for pin 1. While an enable bit is 0, adc_sel for that pin is 1 and the pin is released (pin_oe=0, pin_pu=1, pin_out=0) whatever its latch bit is.
- R5: Bit 4 of register 0x10 is an active-low half-sync enable. While it is 0:
  - pin 2 drives half_out_val push-pull (pin_oe=1, pin_pu=0);
  - pin 3 is released;
  - half_in follows pin_in[3].
  Otherwise half_in is 0.
- R6: Bit 7 of write-only register 0x0C is an active-low pattern enable. Pin 4 drives pattern_val push-pull (pin_oe=1, pin_pu=0) only while that bit is 0 and free_run is 1. Otherwise pin 4 behaves as an ordinary port pin.
- R7: Two read/write registers hold the active-high interrupt enables: bit 7 of 0x18 for pin 5 and bit 6 of 0x1B for pin 6.
  - A read of either register returns the enable in that same bit, with every other bit 0.
  - An enabled pin is released.
- R8: Each interrupt pin is sampled every clock. The routed level takes a new value only when the two most recent samples agree, so a one-cycle glitch never passes. int_lvl[k] shows the filtered level while interrupt k is enabled and 1 while it is disabled.
- R9: Reads of 0x0C, 0x10 and any unimplemented address return 0x00.
- R10: Writes to unimplemented addresses, and to unimplemented bits of implemented registers, change no pin drive, routing or readback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register address for writes and reads |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| pin_in | input | 7 | Sampled pad levels |
| pin_out | output | 7 | Strong-drive value per pin |
| pin_oe | output | 7 | Strong-drive enable per pin |
| pin_pu | output | 7 | Weak pull-up enable per pin |
| free_run | input | 1 | Sync logic is in free-running mode |
| half_out_val | input | 1 | Half-sync output value from the sync logic |
| pattern_val | input | 1 | Self-test pattern value from the sync logic |
| adc_sel | output | 2 | Pin 0/1 handed to analog input 0/1 |
| half_in | output | 1 | Routed half-sync input level |
| int_lvl | output | 2 | Filtered interrupt input levels for pins 5/6 |

## Verification
The embedded properties assume that bus_we, bus_addr and bus_wdata are stable around each rising edge. They also assume that pin_in is a level already sampled into the clock domain, so one value per cycle is meaningful for the interrupt filter. The bench drives every input just after the falling edge and holds it until the next falling edge.

The bench works in two phases. The directed phase steps through each pin takeover, the pattern gating by free_run, and single-cycle and two-cycle pulses on an interrupt pin. The random phase mixes writes to implemented and unimplemented addresses with pin activity that changes every cycle. Every cycle, each output is compared with a behavioural model.

// File: rtl/qbio_pkg.sv
// Package: shared constants and control type for the quasi-bidirectional port.
// Assumes an 8-bit register bus and a 7-pin port.
package qbio_pkg;
    localparam int PORT_W  = 7;
    localparam int BUS_W   = 8;
    localparam int ADDR_W  = 8;
    localparam int NUM_AN  = 2;
    localparam int NUM_INT = 2;

    // Register addresses
    localparam logic [ADDR_W-1:0] A_DATA   = 8'h01;
    localparam logic [ADDR_W-1:0] A_PATCTL = 8'h0C;
    localparam logic [ADDR_W-1:0] A_ANCTL  = 8'h10;
    localparam logic [ADDR_W-1:0] A_IE0    = 8'h18;
    localparam logic [ADDR_W-1:0] A_IE1    = 8'h1B;

    // Control bit positions
    localparam int B_PAT_N  = 7;
    localparam int B_AN0_N  = 0;
    localparam int B_HALF_N = 4;
    localparam int B_IE0    = 7;
    localparam int B_IE1    = 6;

    // Pin roles
    localparam int P_AN0  = 0;
    localparam int P_HOUT = 2;
    localparam int P_HIN  = 3;
    localparam int P_PAT  = 4;
    localparam int P_INT0 = 5;

    typedef struct packed {
        logic [NUM_AN-1:0]  an_n;    // active-low analog takeover
        logic               half_n;  // active-low half-sync takeover
        logic               pat_n;   // active-low pattern takeover
        logic [NUM_INT-1:0] ie;      // active-high interrupt takeover
    } qbio_ctl_t;
endpackage

// File: rtl/qbio_regs.sv
// Module: register file of the port. Holds the output latch and the takeover
// control bits, and forms the combinational read data.
// Assumes bus signals are stable around the rising clock edge.
module qbio_regs
    import qbio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    input  logic [PORT_W-1:0] pin_in,
    output logic [PORT_W-1:0] latch,
    output qbio_ctl_t         ctl,
    output logic [BUS_W-1:0]  rdata
);
    localparam int PAD = BUS_W - PORT_W;

    // Register writes; only implemented bits are stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch  <= '1;
            ctl.an_n   <= '1;
            ctl.half_n <= 1'b1;
            ctl.pat_n  <= 1'b1;
            ctl.ie     <= '0;
        end else if (we) begin
            case (addr)
                A_DATA:   latch <= wdata[PORT_W-1:0];
                A_PATCTL: ctl.pat_n <= wdata[B_PAT_N];
                A_ANCTL: begin
                    ctl.an_n   <= wdata[B_AN0_N +: NUM_AN];
                    ctl.half_n <= wdata[B_HALF_N];
                end
                A_IE0:    ctl.ie[0] <= wdata[B_IE0];
                A_IE1:    ctl.ie[1] <= wdata[B_IE1];
                default: ;
            endcase
        end
    end

    // Read mux: pin levels, interrupt enables, zero elsewhere.
    always_comb begin
        rdata = '0;
        case (addr)
            A_DATA: rdata = {{PAD{1'b0}}, pin_in};
            A_IE0:  rdata[B_IE0] = ctl.ie[0];
            A_IE1:  rdata[B_IE1] = ctl.ie[1];
            default: rdata = '0;
        endcase
    end

    AST_LATCH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == A_DATA) |=> latch == $past(wdata[PORT_W-1:0])); // R2
    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && addr == A_DATA) |=> $stable(latch)); // R10
    AST_WO_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == A_PATCTL || addr == A_ANCTL) |-> rdata == '0); // R9
endmodule

// File: rtl/qbio_pinmux.sv
// Module: per-pin drive selection. Each pin is an ordinary quasi-bidirectional
// line, released (pull-up only) for an input takeover, or push-pull for an
// output takeover.
// Assumes control bits come from qbio_regs.
module qbio_pinmux
    import qbio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] latch,
    input  qbio_ctl_t         ctl,
    input  logic              free_run,
    input  logic              half_val,
    input  logic              pat_val,
    output logic [PORT_W-1:0] pin_out,
    output logic [PORT_W-1:0] pin_oe,
    output logic [PORT_W-1:0] pin_pu
);
    logic [PORT_W-1:0] released;
    logic [PORT_W-1:0] push;
    logic [PORT_W-1:0] push_val;

    // Decode which pins are taken over and by which kind of function.
    always_comb begin
        released = '0;
        push     = '0;
        push_val = '0;
        for (int k = 0; k < NUM_AN; k++) released[P_AN0 + k] = ~ctl.an_n[k];
        released[P_HIN]  = ~ctl.half_n;
        push[P_HOUT]     = ~ctl.half_n;
        push_val[P_HOUT] = half_val;
        push[P_PAT]      = ~ctl.pat_n & free_run;
        push_val[P_PAT]  = pat_val;
        for (int k = 0; k < NUM_INT; k++) released[P_INT0 + k] = ctl.ie[k];
    end

    // Per-pin driver: push-pull, released, or quasi-bidirectional.
    for (genvar i = 0; i < PORT_W; i++) begin : g_pin
        assign pin_oe[i]  = push[i] | (~released[i] & ~latch[i]);
        assign pin_out[i] = push[i] & push_val[i];
        assign pin_pu[i]  = ~push[i] & (released[i] | latch[i]);
    end

    AST_ADC_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl.an_n[0] |-> (!pin_oe[P_AN0] && pin_pu[P_AN0])); // R4
    AST_HALF_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl.half_n |-> (pin_oe[P_HOUT] && pin_out[P_HOUT] == half_val && !pin_oe[P_HIN])); // R5
    AST_PATTERN_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl.pat_n && free_run) |-> (pin_oe[P_PAT] && pin_out[P_PAT] == pat_val && !pin_pu[P_PAT])); // R6
    AST_INT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.ie[0] |-> (!pin_oe[P_INT0] && pin_pu[P_INT0])); // R7
endmodule

// File: rtl/qbio_hyst.sv
// Module: two-sample input filter with hysteresis for an interrupt pin.
// The output level changes only when two consecutive samples agree.
// Assumes the input is already a level in the clock domain.
module qbio_hyst #(
    parameter logic IDLE_LVL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic lvl
);
    logic samp_new;
    logic samp_old;

    // Sample shift and hysteretic level update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            samp_new <= IDLE_LVL;
            samp_old <= IDLE_LVL;
            lvl      <= IDLE_LVL;
        end else begin
            samp_new <= din;
            samp_old <= samp_new;
            if (samp_new == samp_old) lvl <= samp_new;
        end
    end

    AST_GLITCH_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lvl) |-> ($past(samp_new) == $past(samp_old) && lvl == $past(samp_new))); // R8
endmodule

// File: rtl/qbio_port.sv
// Module: top of the quasi-bidirectional port with shared pin functions.
// Ties together the register file, the pin multiplexer and the interrupt
// input filters. Assumes pin_in is synchronous to clk.
module qbio_port
    import qbio_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [BUS_W-1:0]   bus_wdata,
    output logic [BUS_W-1:0]   bus_rdata,
    input  logic [PORT_W-1:0]  pin_in,
    output logic [PORT_W-1:0]  pin_out,
    output logic [PORT_W-1:0]  pin_oe,
    output logic [PORT_W-1:0]  pin_pu,
    input  logic               free_run,
    input  logic               half_out_val,
    input  logic               pattern_val,
    output logic [NUM_AN-1:0]  adc_sel,
    output logic               half_in,
    output logic [NUM_INT-1:0] int_lvl
);
    logic [PORT_W-1:0] latch;
    qbio_ctl_t         ctl;

    qbio_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (bus_we),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .pin_in(pin_in),
        .latch (latch),
        .ctl   (ctl),
        .rdata (bus_rdata)
    );

    qbio_pinmux u_pinmux (
        .clk     (clk),
        .rst_n   (rst_n),
        .latch   (latch),
        .ctl     (ctl),
        .free_run(free_run),
        .half_val(half_out_val),
        .pat_val (pattern_val),
        .pin_out (pin_out),
        .pin_oe  (pin_oe),
        .pin_pu  (pin_pu)
    );

    // Routed peripheral inputs
    assign adc_sel = ~ctl.an_n;
    assign half_in = ~ctl.half_n & pin_in[P_HIN];

    // One filter per interrupt pin; disabled lines read idle high.
    for (genvar k = 0; k < NUM_INT; k++) begin : g_int
        logic filt;
        qbio_hyst #(.IDLE_LVL(1'b1)) u_hyst (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (pin_in[P_INT0 + k]),
            .lvl  (filt)
        );
        assign int_lvl[k] = ctl.ie[k] ? filt : 1'b1;
    end
endmodule

// File: tb/qbio_port_bench.sv
// Bench: behavioural reference model compared with the port on every clock.
module qbio_port_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [6:0] pin_in = 7'h7F;
    logic [6:0] pin_out, pin_oe, pin_pu;
    logic       free_run = 1'b0, half_out_val = 1'b0, pattern_val = 1'b0;
    logic [1:0] adc_sel, int_lvl;
    logic       half_in;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    qbio_port u_qbio_port (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu),
        .free_run(free_run), .half_out_val(half_out_val),
        .pattern_val(pattern_val), .adc_sel(adc_sel), .half_in(half_in),
        .int_lvl(int_lvl)
    );

    // Reference model state
    logic [6:0] m_latch;
    logic [1:0] m_an_n;
    logic       m_half_n, m_pat_n;
    logic [1:0] m_ie;
    logic [1:0] m_lvl;
    logic       h5[$];
    logic       h6[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_latch = 7'h7F; m_an_n = 2'b11; m_half_n = 1'b1; m_pat_n = 1'b1;
            m_ie = 2'b00; m_lvl = 2'b11;
            h5 = '{1'b1, 1'b1}; h6 = '{1'b1, 1'b1};
        end else begin
            if (h5[0] == h5[1]) m_lvl[0] = h5[1];
            if (h6[0] == h6[1]) m_lvl[1] = h6[1];
            h5.push_back(pin_in[5]); void'(h5.pop_front());
            h6.push_back(pin_in[6]); void'(h6.pop_front());
            if (bus_we) begin
                case (bus_addr)
                    8'h01: m_latch = bus_wdata[6:0];
                    8'h0C: m_pat_n = bus_wdata[7];
                    8'h10: begin m_an_n = bus_wdata[1:0]; m_half_n = bus_wdata[4]; end
                    8'h18: m_ie[0] = bus_wdata[7];
                    8'h1B: m_ie[1] = bus_wdata[6];
                    default: ;
                endcase
            end
        end
    end

    task automatic check(input bit ok, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", what, act, exp, $time);
        end
    endtask

    task automatic compare();
        logic [6:0] e_oe, e_out, e_pu;
        logic [7:0] e_rd;
        for (int i = 0; i < 7; i++) begin
            bit rel, pp, pv;
            rel = 0; pp = 0; pv = 0;
            if (i == 0 && !m_an_n[0]) rel = 1;
            if (i == 1 && !m_an_n[1]) rel = 1;
            if (i == 3 && !m_half_n) rel = 1;
            if (i == 5 && m_ie[0]) rel = 1;
            if (i == 6 && m_ie[1]) rel = 1;
            if (i == 2 && !m_half_n) begin pp = 1; pv = half_out_val; end
            if (i == 4 && !m_pat_n && free_run) begin pp = 1; pv = pattern_val; end
            if (pp) begin e_oe[i] = 1; e_out[i] = pv; e_pu[i] = 0; end
            else if (rel) begin e_oe[i] = 0; e_out[i] = 0; e_pu[i] = 1; end
            else begin e_oe[i] = !m_latch[i]; e_out[i] = 0; e_pu[i] = m_latch[i]; end
        end
        case (bus_addr)
            8'h01: e_rd = {1'b0, pin_in};
            8'h18: e_rd = m_ie[0] ? 8'h80 : 8'h00;
            8'h1B: e_rd = m_ie[1] ? 8'h40 : 8'h00;
            default: e_rd = 8'h00;
        endcase
        check(pin_oe === e_oe, "R2/R4/R5/R6/R7 pin_oe", {1'b0, pin_oe}, {1'b0, e_oe});
        check(pin_out === e_out, "R2/R5/R6 pin_out", {1'b0, pin_out}, {1'b0, e_out});
        check(pin_pu === e_pu, "R2/R4/R7 pin_pu", {1'b0, pin_pu}, {1'b0, e_pu});
        check(bus_rdata === e_rd, "R3/R7/R9 bus_rdata", bus_rdata, e_rd);
        check(adc_sel === ~m_an_n, "R4 adc_sel", {6'd0, adc_sel}, {6'd0, ~m_an_n});
        check(half_in === (!m_half_n && pin_in[3]), "R5 half_in", {7'd0, half_in},
              {7'd0, (!m_half_n && pin_in[3])});
        check(int_lvl[0] === (m_ie[0] ? m_lvl[0] : 1'b1), "R8 int_lvl0", {7'd0, int_lvl[0]},
              {7'd0, (m_ie[0] ? m_lvl[0] : 1'b1)});
        check(int_lvl[1] === (m_ie[1] ? m_lvl[1] : 1'b1), "R8 int_lvl1", {7'd0, int_lvl[1]},
              {7'd0, (m_ie[1] ? m_lvl[1] : 1'b1)});
    endtask

    // One bus cycle: drive, compare, advance to the next falling edge.
    task automatic cyc(input logic we, input logic [7:0] a, input logic [7:0] d);
        bus_we = we; bus_addr = a; bus_wdata = d;
        #1;
        compare();
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(pin_oe === 7'h00, "R1 reset pin_oe", {1'b0, pin_oe}, 8'h00);
        check(pin_pu === 7'h7F, "R1 reset pin_pu", {1'b0, pin_pu}, 8'h7F);
        check(int_lvl === 2'b11 && adc_sel === 2'b00 && half_in === 1'b0, "R1 reset routing",
              {3'd0, half_in, adc_sel, int_lvl}, 8'h03);
        cyc(0, 8'h01, 8'h00);

        // R2 latch patterns and R3 readback
        foreach (pin_in[i]) ;
        cyc(1, 8'h01, 8'h55); cyc(0, 8'h01, 8'h00);
        check(pin_oe === 7'h2A, "R2 latch 0x55 drive", {1'b0, pin_oe}, 8'h2A);
        pin_in = 7'h13;
        cyc(1, 8'h01, 8'hAA); cyc(0, 8'h01, 8'h00);
        check(bus_rdata === 8'h13, "R3 read pins not latch", bus_rdata, 8'h13);
        cyc(1, 8'h01, 8'h00); cyc(0, 8'h00, 8'h00);
        cyc(1, 8'h01, 8'hFF); cyc(0, 8'h0C, 8'h00);

        // R10 unimplemented address and bits
        cyc(1, 8'h01, 8'h00); cyc(1, 8'h05, 8'hFF); cyc(1, 8'h18, 8'h7F);
        cyc(1, 8'h1B, 8'hBF); cyc(0, 8'h18, 8'h00);
        check(pin_oe === 7'h7F && bus_rdata === 8'h00, "R10 ignored writes",
              {1'b0, pin_oe}, 8'h7F);

        // R4 / R5 takeover over a low latch
        cyc(1, 8'h10, 8'hFC); cyc(0, 8'h10, 8'h00);
        check(pin_oe[1:0] === 2'b00 && adc_sel === 2'b11, "R4 analog release",
              {6'd0, pin_oe[1:0]}, 8'h00);
        pin_in = 7'h08; half_out_val = 1'b1;
        cyc(1, 8'h10, 8'hEF); cyc(0, 8'h10, 8'h00);
        check(pin_out[2] === 1'b1 && half_in === 1'b1, "R5 half pair",
              {6'd0, pin_out[2], half_in}, 8'h03);
        half_out_val = 1'b0; cyc(0, 8'h00, 8'h00);

        // R6 pattern gated by free_run
        cyc(1, 8'h01, 8'hFF); cyc(1, 8'h0C, 8'h7F);
        pattern_val = 1'b1; cyc(0, 8'h00, 8'h00);
        check(pin_oe[4] === 1'b0 && pin_pu[4] === 1'b1, "R6 no pattern without free_run",
              {6'd0, pin_oe[4], pin_pu[4]}, 8'h01);
        free_run = 1'b1; cyc(0, 8'h00, 8'h00);
        check(pin_oe[4] === 1'b1 && pin_out[4] === 1'b1, "R6 pattern drive",
              {6'd0, pin_oe[4], pin_out[4]}, 8'h03);
        pattern_val = 1'b0; cyc(0, 8'h00, 8'h00); free_run = 1'b0;

        // R7 / R8 interrupt pin filtering
        pin_in = 7'h7F;
        cyc(1, 8'h18, 8'h80); cyc(1, 8'h1B, 8'h40); cyc(0, 8'h18, 8'h00);
        check(bus_rdata === 8'h80, "R7 ie0 readback", bus_rdata, 8'h80);
        cyc(0, 8'h1B, 8'h00);
        check(bus_rdata === 8'h40, "R7 ie1 readback", bus_rdata, 8'h40);
        pin_in[5] = 1'b0; cyc(0, 8'h00, 8'h00);
        pin_in[5] = 1'b1; cyc(0, 8'h00, 8'h00); cyc(0, 8'h00, 8'h00); cyc(0, 8'h00, 8'h00);
        check(int_lvl[0] === 1'b1, "R8 one-cycle glitch rejected", {7'd0, int_lvl[0]}, 8'h01);
        pin_in[5] = 1'b0; cyc(0, 8'h00, 8'h00); cyc(0, 8'h00, 8'h00);
        pin_in[5] = 1'b1; cyc(0, 8'h00, 8'h00);
        #1;
        check(int_lvl[0] === 1'b0, "R8 two-cycle pulse passes", {7'd0, int_lvl[0]}, 8'h00);
        repeat (4) cyc(0, 8'h00, 8'h00);

        // Random phase
        for (int n = 0; n < 3000; n++) begin
            logic [7:0] a;
            case ($urandom_range(0, 6))
                0: a = 8'h01; 1: a = 8'h0C; 2: a = 8'h10; 3: a = 8'h18;
                4: a = 8'h1B; 5: a = 8'h02; default: a = 8'($urandom);
            endcase
            pin_in = 7'($urandom);
            if ($urandom_range(0, 3) != 0) pin_in[6:5] = 2'($urandom_range(0, 1) ? 2'b11 : 2'b00);
            free_run = 1'($urandom); half_out_val = 1'($urandom); pattern_val = 1'($urandom);
            cyc(($urandom_range(0, 3) == 0), a, 8'($urandom));
        end

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule